// File: doc/BRIEF.md
# Converter Serial Readout Emulator

This block models, in synthesizable logic, the device side of an 18-bit converter's serial output port in chip-select mode over three wires, without a busy indicator. A host drives a convert strobe and a serial clock. Both are brought into the system clock domain through two-flop synchronizers, and edges are detected on the synchronized levels. A rising strobe starts an internal conversion timer. The timer runs to the end whatever the strobe does next. On the last conversion cycle the block captures the 18-bit word presented on `sample_in`.

Once the conversion is complete and the strobe is low, the word is shifted out MSB first on `sdo`. `sdo_oe` stands in for the pin's tri-state control. When `sdo_oe` is low the port is in high impedance, and `sdo` is forced to 0.

The controller has five states:

| State | Meaning |
|---|---|
| `ST_ACQ` | Reset idle |
| `ST_CONV` | Conversion running |
| `ST_HOLD` | Conversion done, strobe still high |
| `ST_SHIFT` | Driving data |
| `ST_REL` | Released after the last bit |

The transitions are:

| From | To | Condition |
|---|---|---|
| `ST_ACQ`, `ST_HOLD`, `ST_SHIFT`, `ST_REL` | `ST_CONV` | Strobe rise, start |
| `ST_CONV` | `ST_SHIFT` | Timer done with the strobe low, early read |
| `ST_CONV` | `ST_HOLD` | Timer done with the strobe high |
| `ST_HOLD` | `ST_SHIFT` | Strobe fall, read |
| `ST_SHIFT` | `ST_REL` | Clock fall on the last bit, drain |

Top module: `adc_readout_emu`

## Requirements
- R1: After reset, `sdo_oe` and `sdo` are 0 and the controller is idle.
- R2: A synchronized rise of `cnv_in` starts a conversion, and `sdo_oe` goes low by the cycle after detection. This happens from any state other than conversion.
- R3: A conversion lasts exactly CONV_CYC system cycles from the cycle its start is registered. A further rise of `cnv_in` during a conversion neither restarts nor extends it.
- R4: `sample_in` is captured only in the final conversion cycle. Values before or after that cycle have no effect on the shifted word.
- R5: If `cnv_in` is still high when the conversion ends, `sdo_oe` stays low until `cnv_in` falls. After that fall, `sdo` carries bit 17 of the captured word.
- R6: If `cnv_in` fell during the conversion, `sdo_oe` rises in the cycle right after the conversion ends, showing bit 17, and no busy pulse appears beforehand.
- R7: Each synchronized falling edge of `sck_in` moves `sdo` to the next lower bit, in the order 17 down to 0. Between falls `sdo` does not change, so it holds the same value through both clock levels.
- R8: The 18th falling edge of `sck_in` drops `sdo_oe`. Further clock edges keep it low until a new conversion starts.
- R9: A rise of `cnv_in` during readout drops `sdo_oe` before all 18 bits are sent and starts a new conversion.
- R10: Both inputs pass through two synchronizer stages. An input change takes effect in controller state on the third rising clock edge after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnv_in | input | 1 | Convert strobe / chip select from host (asynchronous) |
| sck_in | input | 1 | Serial clock from host (asynchronous) |
| sample_in | input | 18 | Word to be returned by the next conversion |
| sdo | output | 1 | Serial data, forced 0 while released |
| sdo_oe | output | 1 | Output enable; low models high impedance |

## Verification
Readout is tried with the strobe lowered after the conversion, which tests the hold state. It is also tried with the strobe lowered mid-conversion, which checks that enable waits for the timer. A third run adds a fall, rise and fall inside the conversion, which would expose a restart. Random words with random serial clock half-periods confirm bit order and that each bit holds across both clock levels, and the sample input is changed before and after the capture cycle to pin down the capture instant. Directed runs compare release by the 18th clock fall against release by an early strobe rise, and confirm that extra clock edges after release leave the port off.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
    typedef enum logic [2:0] {
        ST_ACQ   = 3'd0,
        ST_CONV  = 3'd1,
        ST_HOLD  = 3'd2,
        ST_SHIFT = 3'd3,
        ST_REL   = 3'd4
    } rd_state_e;
endpackage

// File: rtl/edge_sync.sv
module edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic level,
    output logic rise,
    output logic fall
);
    logic [STAGES:0] pipe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe <= '0;
        else        pipe <= {pipe[STAGES-1:0], async_in};
    end

    assign level = pipe[STAGES-1];
    assign rise  = pipe[STAGES-1] & ~pipe[STAGES];
    assign fall  = ~pipe[STAGES-1] & pipe[STAGES];

    // R10
    sync_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise |-> $past(pipe[0]));
endmodule

// File: rtl/conv_timer.sv
module conv_timer #(
    parameter int CONV_CYC = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int CNT_W = (CONV_CYC > 2) ? $clog2(CONV_CYC) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CONV_CYC - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            busy <= 1'b0;
        end else if (start && !busy) begin
            cnt  <= '0;
            busy <= 1'b1;
        end else if (busy) begin
            if (cnt == LAST) busy <= 1'b0;
            else             cnt  <= cnt + 1'b1;
        end
    end

    assign done = busy && (cnt == LAST);

    // R3
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (cnt <= LAST));
    // R3
    no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> (busy && cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/bit_shifter.sv
module bit_shifter #(
    parameter int WIDTH = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] load_word,
    input  logic             step,
    output logic             bit_out,
    output logic             last
);
    localparam int IDX_W = $clog2(WIDTH);
    localparam logic [IDX_W-1:0] TOP = IDX_W'(WIDTH - 1);

    logic [WIDTH-1:0] word;
    logic [IDX_W-1:0] idx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word <= '0;
            idx  <= TOP;
        end else if (load) begin
            word <= load_word;
            idx  <= TOP;
        end else if (step && idx != '0) begin
            idx  <= idx - 1'b1;
        end
    end

    assign bit_out = word[idx];
    assign last    = (idx == '0);

    // R7
    idx_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !step) |=> $stable(idx));
endmodule

// File: rtl/adc_readout_emu.sv
module adc_readout_emu
    import adc_rd_pkg::*;
#(
    parameter int DATA_W   = 18,
    parameter int CONV_CYC = 40,
    parameter int SYNC_N   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnv_in,
    input  logic              sck_in,
    input  logic [DATA_W-1:0] sample_in,
    output logic              sdo,
    output logic              sdo_oe
);
    rd_state_e state, state_nx;

    logic cnv_lvl, cnv_rise, cnv_fall;
    logic sck_lvl, sck_rise, sck_fall;
    logic tmr_start, tmr_busy, tmr_done;
    logic sh_bit, sh_last;

    edge_sync #(.STAGES(SYNC_N)) u_cnv_sync (
        .clk(clk), .rst_n(rst_n), .async_in(cnv_in),
        .level(cnv_lvl), .rise(cnv_rise), .fall(cnv_fall)
    );

    edge_sync #(.STAGES(SYNC_N)) u_sck_sync (
        .clk(clk), .rst_n(rst_n), .async_in(sck_in),
        .level(sck_lvl), .rise(sck_rise), .fall(sck_fall)
    );

    assign tmr_start = cnv_rise && (state != ST_CONV);

    conv_timer #(.CONV_CYC(CONV_CYC)) u_timer (
        .clk(clk), .rst_n(rst_n), .start(tmr_start),
        .busy(tmr_busy), .done(tmr_done)
    );

    bit_shifter #(.WIDTH(DATA_W)) u_shift (
        .clk(clk), .rst_n(rst_n),
        .load(tmr_done), .load_word(sample_in),
        .step(sck_fall && state == ST_SHIFT),
        .bit_out(sh_bit), .last(sh_last)
    );

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_ACQ:   if (cnv_rise) state_nx = ST_CONV;
            ST_CONV:  if (tmr_done) state_nx = cnv_lvl ? ST_HOLD : ST_SHIFT;
            ST_HOLD: begin
                if (cnv_rise)      state_nx = ST_CONV;
                else if (cnv_fall) state_nx = ST_SHIFT;
            end
            ST_SHIFT: begin
                if (cnv_rise)                state_nx = ST_CONV;
                else if (sck_fall && sh_last) state_nx = ST_REL;
            end
            ST_REL:   if (cnv_rise) state_nx = ST_CONV;
            default:  state_nx = ST_ACQ;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_ACQ;
        else        state <= state_nx;
    end

    // outputs
    always_comb begin
        unique case (state)
            ST_SHIFT: begin sdo_oe = 1'b1; sdo = sh_bit; end
            default:  begin sdo_oe = 1'b0; sdo = 1'b0;   end
        endcase
    end

    // R2
    start_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnv_rise |=> !sdo_oe);
    // R3
    conv_timer_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CONV) |-> tmr_busy);
    // R5
    enable_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sdo_oe) |-> ($past(tmr_done) || $past(cnv_fall)));
    // R7
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sdo_oe && $past(sdo_oe) && !$past(sck_fall)) |-> $stable(sdo));
    // R8
    last_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sdo_oe && sck_fall && sh_last) |=> !sdo_oe);
    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sdo_oe |-> !sdo);
endmodule

// File: tb/sim_adc_readout_emu.sv
module sim_adc_readout_emu;
    localparam int TCLK  = 10;
    localparam int W     = 18;
    localparam int CONV  = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cnv_in = 1'b0;
    logic sck_in = 1'b0;
    logic [W-1:0] sample_in = '0;
    logic sdo, sdo_oe;

    int total = 0;
    int bad = 0;

    always #(TCLK/2) clk = ~clk;

    adc_readout_emu #(.DATA_W(W), .CONV_CYC(CONV), .SYNC_N(2)) u0 (
        .clk(clk), .rst_n(rst_n), .cnv_in(cnv_in), .sck_in(sck_in),
        .sample_in(sample_in), .sdo(sdo), .sdo_oe(sdo_oe)
    );

    function automatic logic exp_bit(input logic [W-1:0] w, input int k);
        return w[W-1-k];
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic waitn(input int n);
        repeat (n) @(negedge clk);
    endtask

    // mode 0: CNV held high through conversion; 1: falls mid-way; 2: fall, rise, fall
    task automatic convert(input logic [W-1:0] word, input int mode);
        @(negedge clk);
        cnv_in = 1'b1;
        sample_in = ~word;
        for (int n = 1; n <= CONV + 3; n++) begin
            @(negedge clk);
            if (n == CONV) sample_in = word;
            if (mode != 0 && n == 8)  cnv_in = 1'b0;
            if (mode == 2 && n == 14) cnv_in = 1'b1;
            if (mode == 2 && n == 20) cnv_in = 1'b0;
            if (n == CONV + 2) chk("R3 no enable before end", 32'(sdo_oe), 0);
        end
        sample_in = word ^ 18'h2AAAA;
        if (mode == 0) begin
            chk("R5 held until CNV falls", 32'(sdo_oe), 0);
            waitn(6);
            chk("R5 still off while CNV high", 32'(sdo_oe), 0);
            cnv_in = 1'b0;
            waitn(4);
        end
        chk("R6 R5 enable after conversion", 32'(sdo_oe), 1);
        chk("R4 R5 MSB first", 32'(sdo), 32'(exp_bit(word, 0)));
    endtask

    task automatic read_bits(input logic [W-1:0] word, input int nbits, input int hmax);
        for (int k = 0; k < nbits; k++) begin
            int h;
            h = 4 + int'($urandom % (hmax - 3));
            chk("R7 bit before rise", 32'(sdo), 32'(exp_bit(word, k)));
            sck_in = 1'b1;
            waitn(h);
            chk("R7 bit stable while SCK high", 32'(sdo), 32'(exp_bit(word, k)));
            sck_in = 1'b0;
            waitn(h);
        end
    endtask

    initial begin
        logic [W-1:0] w;
        void'($urandom(32'd2024));
        waitn(3);
        chk("R1 reset oe", 32'(sdo_oe), 0);
        chk("R1 reset sdo", 32'(sdo), 0);
        rst_n = 1'b1;
        waitn(2);
        sck_in = 1'b1; waitn(4); sck_in = 1'b0; waitn(4);
        chk("R1 idle ignores SCK", 32'(sdo_oe), 0);

        // R10 latency: rise registered on the third posedge
        @(negedge clk); cnv_in = 1'b1;
        waitn(2);
        chk("R10 no effect before third edge", 32'(sdo_oe), 0);
        waitn(CONV + 6);
        cnv_in = 1'b0;
        waitn(2);
        chk("R10 CNV fall not yet seen", 32'(sdo_oe), 0);
        waitn(1);
        chk("R10 CNV fall seen at third edge", 32'(sdo_oe), 1);
        cnv_in = 1'b0;
        read_bits(w, 0, 5);

        // directed full reads, each CNV pattern
        w = 18'h2D3C5; convert(w, 0); read_bits(w, W, 6);
        chk("R8 release after 18th fall", 32'(sdo_oe), 0);
        chk("R8 sdo zero when released", 32'(sdo), 0);
        sck_in = 1'b1; waitn(5); sck_in = 1'b0; waitn(5);
        chk("R8 extra SCK keeps released", 32'(sdo_oe), 0);

        w = 18'h3FFFE; convert(w, 1); read_bits(w, W, 5);
        chk("R8 release all-ones word", 32'(sdo_oe), 0);
        w = 18'h00001; convert(w, 2); read_bits(w, W, 5);
        chk("R3 ignored rise then R8 release", 32'(sdo_oe), 0);

        // R9 early release by CNV rise during readout
        w = 18'h15A3C; convert(w, 1); read_bits(w, 5, 5);
        chk("R9 still driving mid-read", 32'(sdo_oe), 1);
        @(negedge clk); cnv_in = 1'b1;
        sample_in = 18'h0F0F0;
        waitn(4);
        chk("R9 early release", 32'(sdo_oe), 0);
        chk("R2 sdo low after release", 32'(sdo), 0);
        waitn(CONV + 4);
        cnv_in = 1'b0;
        waitn(4);
        chk("R9 R2 new conversion result enabled", 32'(sdo_oe), 1);
        read_bits(18'h0F0F0, W, 5);
        chk("R8 release after restarted read", 32'(sdo_oe), 0);

        // random words, modes and clock rates
        for (int it = 0; it < 20; it++) begin
            logic [W-1:0] rw;
            int md;
            rw = W'($urandom);
            md = int'($urandom % 3);
            convert(rw, md);
            read_bits(rw, W, 4 + int'($urandom % 5));
            chk("R8 random release", 32'(sdo_oe), 0);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule